// File: doc/BRIEF.md
# Embedded sync video decoder

This block takes an 8-bit video byte stream, one byte per pixel clock, in which line timing is carried in-band. A three-byte preamble (FF, 00, 00) followed by a code byte marks a delimiter. Code 80 opens the active-video window of a line, and code 9D closes it. No separate horizontal or vertical sync pins are needed. The decoder rebuilds line and frame timing from these delimiters. It forwards only the bytes inside the active window, tags each one with its colour component, and marks the first pixel of every line and of every frame.

A line whose delimiters enclose no pixel is taken as vertical blanking. The first pixel that follows a blanking line starts a new frame. After reset no frame start is reported until one blanking line has been seen. A one-cycle event pulse reports each detected delimiter, for use as an interrupt source.

Top module: `embsync_decoder`

## Requirements
- R1: While reset is asserted and after its release, every output is 0 until stream bytes cause activity.
- R2: The sequence FF, 00, 00, 80 on consecutive bytes raises `ev_sav` for exactly the one cycle after the 80 byte is sampled.
- R3: The sequence FF, 00, 00, 9D on consecutive bytes raises `ev_eav` for exactly the one cycle after the 9D byte is sampled.
- R4: Only bytes sampled after an 80 code and before the preamble of the next code are presented on `pix_byte` with `pix_vld` high. Each appears in order, 3 cycles after the cycle in which it was sampled. Preamble, code and blanking bytes never appear.
- R5: `pix_comp` tags each pixel in the repeating order 0 (Y), 1 (Cb), 2 (Y), 3 (Cr). The order restarts at 0 after every 80 code.
- R6: `pix_sol` is high with the first pixel after each 80 code and low with every other pixel.
- R7: An EAV code with no pixel sampled since the previous delimiter is a blanking line, and `ev_vblank` rises together with its `ev_eav`. This covers an 80 code directly followed by the 9D sequence, and two consecutive 9D sequences.
- R8: `pix_sof` is high only with the first pixel after a blanking line. No frame start is reported before the first blanking line after reset.
- R9: A preamble followed by any code byte other than 80 or 9D raises no event. A preamble followed by a non-code byte inside the active window is forwarded as four ordinary pixels.
- R10: Reset taken in the middle of an active line clears the window, the history and the frame state. Bytes after release are not pixels until a new 80 code arrives, and that line carries no frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; one stream byte per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_byte | input | 8 | Incoming video byte |
| pix_vld | output | 1 | Pixel strobe |
| pix_byte | output | 8 | Pixel data, valid with `pix_vld` |
| pix_comp | output | 2 | Component tag: 0 Y, 1 Cb, 2 Y, 3 Cr |
| pix_sol | output | 1 | First pixel of a line |
| pix_sof | output | 1 | First pixel of a frame |
| ev_sav | output | 1 | Start-of-active-video delimiter detected |
| ev_eav | output | 1 | End-of-active-video delimiter detected |
| ev_vblank | output | 1 | Detected EAV closed a blanking line |

## Verification
The hardest cases to reach are the ones where the delimiter preamble itself must be told apart from pixel data. One is an active window that ends right after its start code. Another is pixel data that contains FF, 00, 00 followed by a non-code byte. A third is two end codes back to back. The stimulus is a hand-built byte stream that places each of these patterns at a known cycle, next to ordinary data lines. Frame-start withholding is reached by asserting reset in the middle of a line and then sending a data line before any blanking line.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PRE_N   = 3;
  localparam logic [7:0]  CODE_SOA = 8'h80;
  localparam logic [7:0]  CODE_EOA = 8'h9D;

  typedef enum logic [1:0] {
    COMP_Y0 = 2'd0,
    COMP_CB = 2'd1,
    COMP_Y1 = 2'd2,
    COMP_CR = 2'd3
  } comp_e;
endpackage

// File: rtl/esd_code_detect.sv
// Byte history and delimiter recognition.
module esd_code_detect #(
  parameter int unsigned DW       = 8,
  parameter int unsigned PRE_LEN  = 3,
  parameter logic [DW*PRE_LEN-1:0] PRE_BYTES = {8'hFF, 8'h00, 8'h00},
  parameter logic [DW-1:0] SOA_CODE = 8'h80,
  parameter logic [DW-1:0] EOA_CODE = 8'h9D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic          hit_soa,
  output logic          hit_eoa,
  output logic [DW-1:0] old_byte
);
  localparam int unsigned LAST = PRE_LEN - 1;

  logic [DW-1:0] hist_q [PRE_LEN];
  logic [DW-1:0] hist_d [PRE_LEN];
  logic [PRE_LEN-1:0] slot_ok;
  logic pre_ok;

  // entry 0 holds the newest byte; entry LAST the oldest
  always_comb begin
    hist_d[0] = din;
    for (int i = 1; i < PRE_LEN; i++) begin
      hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= hist_d[i];
    end
  end

  generate
    for (genvar g = 0; g < PRE_LEN; g++) begin : g_cmp
      assign slot_ok[g] = (hist_q[g] == PRE_BYTES[g*DW +: DW]);
    end
  endgenerate

  assign pre_ok   = &slot_ok;
  assign hit_soa  = pre_ok && (din == SOA_CODE);
  assign hit_eoa  = pre_ok && (din == EOA_CODE);
  assign old_byte = hist_q[LAST];
endmodule

// File: rtl/esd_window.sv
// Active-window state, per-byte pixel tags and blanking-line classification.
module esd_window #(
  parameter int unsigned PRE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_soa,
  input  logic hit_eoa,
  output logic emit,
  output logic blank_line
);
  localparam int unsigned CNT_MAX = PRE_LEN + 1;
  localparam int unsigned CNTW    = $clog2(CNT_MAX + 1);
  localparam logic [CNTW-1:0] CNT_SAT = CNTW'(CNT_MAX);
  localparam logic [CNTW-1:0] CNT_PRE = CNTW'(PRE_LEN);

  logic hit;
  logic active_q, active_d;
  logic [PRE_LEN-1:0] tag_q, tag_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  assign hit = hit_soa | hit_eoa;

  always_comb begin
    active_d = active_q;
    if (hit_soa)      active_d = 1'b1;
    else if (hit_eoa) active_d = 1'b0;
  end

  // a delimiter cancels the preamble bytes still in the history
  always_comb begin
    tag_d[0] = active_q & ~hit;
    for (int i = 1; i < PRE_LEN; i++) begin
      tag_d[i] = tag_q[i-1] & ~hit;
    end
  end

  assign cnt_en = hit | (active_q && (cnt_q != CNT_SAT));

  always_comb begin
    cnt_d = cnt_q;
    if (hit)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tag_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      tag_q    <= tag_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign emit       = tag_q[PRE_LEN-1] & ~hit;
  assign blank_line = hit_eoa && (cnt_q <= CNT_PRE);
endmodule

// File: rtl/esd_pix_out.sv
// Component phase, line/frame marking and output registers.
module esd_pix_out
  import esd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic [DW-1:0] old_byte,
  input  logic          hit_soa,
  input  logic          hit_eoa,
  input  logic          blank_line,
  output logic          pix_vld,
  output logic [DW-1:0] pix_byte,
  output logic [1:0]    pix_comp,
  output logic          pix_sol,
  output logic          pix_sof,
  output logic          ev_sav,
  output logic          ev_eav,
  output logic          ev_vblank
);
  logic [1:0] phase_q, phase_d;
  logic first_q, first_d;
  logic arm_q, arm_d;
  comp_e comp_q;
  logic [DW-1:0] byte_q;
  logic vld_q, sol_q, sof_q, esav_q, eeav_q, eblk_q;

  always_comb begin
    phase_d = phase_q;
    first_d = first_q;
    arm_d   = arm_q;
    if (hit_soa) begin
      phase_d = '0;
      first_d = 1'b1;
    end else if (emit) begin
      phase_d = phase_q + 1'b1;
      first_d = 1'b0;
    end
    if (blank_line)          arm_d = 1'b1;
    else if (emit & first_q) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      first_q <= 1'b0;
      arm_q   <= 1'b0;
      vld_q   <= 1'b0;
      byte_q  <= '0;
      comp_q  <= COMP_Y0;
      sol_q   <= 1'b0;
      sof_q   <= 1'b0;
      esav_q  <= 1'b0;
      eeav_q  <= 1'b0;
      eblk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      first_q <= first_d;
      arm_q   <= arm_d;
      vld_q   <= emit;
      if (emit) begin
        byte_q <= old_byte;
        comp_q <= comp_e'(phase_q);
      end
      sol_q  <= emit & first_q;
      sof_q  <= emit & first_q & arm_q;
      esav_q <= hit_soa;
      eeav_q <= hit_eoa;
      eblk_q <= blank_line;
    end
  end

  assign pix_vld   = vld_q;
  assign pix_byte  = byte_q;
  assign pix_comp  = comp_q;
  assign pix_sol   = sol_q;
  assign pix_sof   = sof_q;
  assign ev_sav    = esav_q;
  assign ev_eav    = eeav_q;
  assign ev_vblank = eblk_q;
endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PRE_LEN = 3,
  parameter logic [DW*PRE_LEN-1:0] PRE_BYTES = {8'hFF, 8'h00, 8'h00},
  parameter logic [DW-1:0] SOA_CODE = esd_pkg::CODE_SOA,
  parameter logic [DW-1:0] EOA_CODE = esd_pkg::CODE_EOA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] vid_byte,
  output logic          pix_vld,
  output logic [DW-1:0] pix_byte,
  output logic [1:0]    pix_comp,
  output logic          pix_sol,
  output logic          pix_sof,
  output logic          ev_sav,
  output logic          ev_eav,
  output logic          ev_vblank
);
  logic hit_soa, hit_eoa, emit, blank_line;
  logic [DW-1:0] old_byte;

  esd_code_detect #(
    .DW(DW), .PRE_LEN(PRE_LEN), .PRE_BYTES(PRE_BYTES),
    .SOA_CODE(SOA_CODE), .EOA_CODE(EOA_CODE)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .din(vid_byte),
    .hit_soa(hit_soa), .hit_eoa(hit_eoa), .old_byte(old_byte)
  );

  esd_window #(.PRE_LEN(PRE_LEN)) u_window (
    .clk(clk), .rst_n(rst_n), .hit_soa(hit_soa), .hit_eoa(hit_eoa),
    .emit(emit), .blank_line(blank_line)
  );

  esd_pix_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .old_byte(old_byte),
    .hit_soa(hit_soa), .hit_eoa(hit_eoa), .blank_line(blank_line),
    .pix_vld(pix_vld), .pix_byte(pix_byte), .pix_comp(pix_comp),
    .pix_sol(pix_sol), .pix_sof(pix_sof),
    .ev_sav(ev_sav), .ev_eav(ev_eav), .ev_vblank(ev_vblank)
  );
endmodule

// File: rtl/esd_chk.sv
module esd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] vid_byte,
  input logic       pix_vld,
  input logic [7:0] pix_byte,
  input logic [1:0] pix_comp,
  input logic       pix_sol,
  input logic       pix_sof,
  input logic       ev_sav,
  input logic       ev_eav,
  input logic       ev_vblank
);
  a_r2_sav_single: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sav |=> !ev_sav);
  a_r2_sav_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sav |-> ($past(vid_byte) == 8'h80 && $past(vid_byte, 4) == 8'hFF));
  a_r3_eav_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eav |-> ($past(vid_byte) == 8'h9D && $past(vid_byte, 4) == 8'hFF));
  a_r4_no_pix_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eav |-> !pix_vld);
  a_r4_pix_latency: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> (pix_byte == $past(vid_byte, 4)));
  a_r5_sol_comp: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> (pix_comp == 2'd0));
  a_r6_sol_vld: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> pix_vld);
  a_r7_vblank_eav: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vblank |-> ev_eav);
  a_r8_sof_sol: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_sol);
  a_r9_events_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sav, ev_eav}));
endmodule

bind embsync_decoder esd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte),
  .pix_vld(pix_vld), .pix_byte(pix_byte), .pix_comp(pix_comp),
  .pix_sol(pix_sol), .pix_sof(pix_sof),
  .ev_sav(ev_sav), .ev_eav(ev_eav), .ev_vblank(ev_vblank)
);

// File: tb/embsync_decoder_tb.sv
module embsync_decoder_tb;
  logic clk;
  logic rst_n;
  logic [7:0] vid_byte;
  logic pix_vld, pix_sol, pix_sof, ev_sav, ev_eav, ev_vblank;
  logic [7:0] pix_byte;
  logic [1:0] pix_comp;
  int n_chk = 0;
  int n_bad = 0;

  embsync_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte),
    .pix_vld(pix_vld), .pix_byte(pix_byte), .pix_comp(pix_comp),
    .pix_sol(pix_sol), .pix_sof(pix_sof),
    .ev_sav(ev_sav), .ev_eav(ev_eav), .ev_vblank(ev_vblank)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // entry: [14:12] kind, [11:4] byte, [3:2] comp, [1] sol, [0] sof
  localparam logic [2:0] K_NO = 3'd0, K_PX = 3'd1, K_SV = 3'd2, K_EV = 3'd3, K_EB = 3'd4;

  function automatic logic [14:0] nb(input logic [7:0] b);
    return {K_NO, b, 4'b0};
  endfunction
  function automatic logic [14:0] px(input logic [7:0] b, input logic [1:0] c,
                                     input logic s, input logic f);
    return {K_PX, b, c, s, f};
  endfunction

  localparam logic [14:0] PF = {K_NO, 8'hFF, 4'b0};
  localparam logic [14:0] P0 = {K_NO, 8'h00, 4'b0};
  localparam logic [14:0] SV = {K_SV, 8'h80, 4'b0};
  localparam logic [14:0] EV = {K_EV, 8'h9D, 4'b0};
  localparam logic [14:0] EB = {K_EB, 8'h9D, 4'b0};

  localparam int NV = 63;
  localparam logic [14:0] VEC [NV] = '{
    // data line before any blanking: no frame start (R8)
    PF, P0, P0, SV,
    px(8'h10,2'd0,1'b1,1'b0), px(8'h20,2'd1,1'b0,1'b0),
    px(8'h30,2'd2,1'b0,1'b0), px(8'h40,2'd3,1'b0,1'b0),
    PF, P0, P0, EV,
    nb(8'h10), nb(8'h80),
    // empty line -> blanking (R7)
    PF, P0, P0, SV, PF, P0, P0, EB,
    // frame start line with preamble-like data and phase wrap (R5, R8, R9)
    PF, P0, P0, SV,
    px(8'h11,2'd0,1'b1,1'b1), px(8'h22,2'd1,1'b0,1'b0),
    px(8'hFF,2'd2,1'b0,1'b0), px(8'h00,2'd3,1'b0,1'b0),
    px(8'h00,2'd0,1'b0,1'b0), px(8'h12,2'd1,1'b0,1'b0),
    PF, P0, P0, EV,
    // preamble with unknown code outside window (R9)
    nb(8'hFF), nb(8'h00), nb(8'h00), nb(8'h81),
    PF, P0, P0, SV,
    px(8'h5A,2'd0,1'b1,1'b0), px(8'h6B,2'd1,1'b0,1'b0),
    PF, P0, P0, EV,
    // two end codes back to back -> blanking (R7)
    PF, P0, P0, EB,
    PF, P0, P0, SV,
    px(8'h77,2'd0,1'b1,1'b1),
    PF, P0, P0, EV
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    vid_byte = b;
    @(posedge clk);
    #2;
  endtask

  task automatic push_pre(input logic [7:0] code);
    push(8'hFF); push(8'h00); push(8'h00); push(code);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] k;
    logic [14:0] e;
    rst_n = 1'b0;
    vid_byte = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    chk({pix_vld, pix_sol, pix_sof, ev_sav, ev_eav, ev_vblank, pix_byte, pix_comp} == '0,
        "R1 reset", {pix_vld, pix_sol, pix_sof, ev_sav, ev_eav, ev_vblank}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    push(8'h00);
    chk({pix_vld, ev_sav, ev_eav, ev_vblank} == '0, "R1 after release",
        {pix_vld, ev_sav, ev_eav, ev_vblank}, 0);

    // table walk
    for (int i = 0; i < NV + 3; i++) begin
      push((i < NV) ? VEC[i][11:4] : 8'h00);
      k = (i < NV) ? VEC[i][14:12] : K_NO;
      case (k)
        K_SV: chk({ev_sav, ev_eav, ev_vblank} == 3'b100, "R2 start code",
                  {ev_sav, ev_eav, ev_vblank}, 3'b100);
        K_EV: chk({ev_sav, ev_eav, ev_vblank} == 3'b010, "R3 end code",
                  {ev_sav, ev_eav, ev_vblank}, 3'b010);
        K_EB: chk({ev_sav, ev_eav, ev_vblank} == 3'b011, "R7 blank line",
                  {ev_sav, ev_eav, ev_vblank}, 3'b011);
        default: chk({ev_sav, ev_eav, ev_vblank} == 3'b000, "R9 no event",
                     {ev_sav, ev_eav, ev_vblank}, 3'b000);
      endcase
      if (i >= 3) begin
        e = VEC[i-3];
        if (e[14:12] == K_PX) begin
          chk(pix_vld && pix_byte == e[11:4], "R4 pixel", {pix_vld, pix_byte},
              {1'b1, e[11:4]});
          chk(pix_comp == e[3:2], "R5 component", pix_comp, e[3:2]);
          chk(pix_sol == e[1], "R6 line start", pix_sol, e[1]);
          chk(pix_sof == e[0], "R8 frame start", pix_sof, e[0]);
        end else begin
          chk(!pix_vld, "R4 no pixel", pix_vld, 0);
        end
      end
    end

    // R10: reset in the middle of an active line
    push_pre(8'h80);
    push(8'hA1);
    push(8'hA2);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({pix_vld, pix_sol, pix_sof, ev_sav, ev_eav, ev_vblank} == '0, "R10 async clear",
        {pix_vld, pix_sol, pix_sof, ev_sav, ev_eav, ev_vblank}, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 7; j++) begin
      push(8'h50 + 8'(j));
      chk(!pix_vld, "R10 window closed", pix_vld, 0);
    end
    push_pre(8'h80);
    chk(ev_sav, "R2 after reset", ev_sav, 1);
    push(8'hB1);
    push(8'hFF); push(8'h00); push(8'h00);
    chk(pix_vld && pix_byte == 8'hB1 && pix_sol, "R10 line start",
        {pix_vld, pix_sol, pix_byte}, {2'b11, 8'hB1});
    chk(!pix_sof, "R10 no frame start", pix_sof, 0);
    push(8'h9D);
    chk(ev_eav && !ev_vblank, "R3 data line end", {ev_eav, ev_vblank}, 2'b10);
    // empty line then data: frame start now reported
    push_pre(8'h80);
    push_pre(8'h9D);
    chk(ev_eav && ev_vblank, "R7 empty line", {ev_eav, ev_vblank}, 2'b11);
    push_pre(8'h80);
    push(8'hC1);
    push(8'hFF); push(8'h00); push(8'h00);
    chk(pix_vld && pix_sof && pix_byte == 8'hC1, "R8 frame after blank",
        {pix_vld, pix_sof, pix_byte}, {2'b11, 8'hC1});
    push(8'h9D);
    push(8'h00);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule